// File: doc/BRIEF.md
# Relocatable Instruction RAM Decoder

This block holds a 4 KB (1024-dword) instruction memory for an on-chip I/O processor. A base register, written from the configuration side, places the memory anywhere in a 32-bit address space on a 4 KB boundary. The processor's instruction fetches that land in that window are answered from the memory on the next cycle and never reach the host bus. Every other processor access, including data reads of the window, is handed to the host-bus path as though the memory lived off-chip.

On the host side, a simple slave port selects the memory by address. It writes single bytes under byte enables and answers after three wait states. An ordinary register slave, flagged by an external decode input, answers after five. A strap input can switch the memory off completely. A control bit makes the scratch register read back the base address, which lets loader software find where the memory was put.

Top module: `reloc_iram_top`

## Requirements
- R1: After reset, `base_q` and `scratch_q` read 0 and `hs_ready` and `cpu_ack` are low. The mirror control bit is cleared.
- R2: The base register keeps only bits [31:12] of `base_wdata`, so `base_q[11:0]` always reads 0.
- R3: An address hits the memory when its bits [31:12] equal `base_q[31:12]` and `ram_en` is high. Its dword index is `addr[11:2]`. A host access that hits the memory is treated as a memory access even when `hs_reg_hit` is also high.
- R4: When `cpu_req` and `cpu_fetch` are high and the address hits, `cpu_bus_req` stays low in that cycle. `cpu_ack` is high in the following cycle, with `cpu_rdata` holding the addressed dword.
- R5: When a processor request is not a fetch, or its address misses, `cpu_bus_req` is high in that same cycle and `cpu_ack` stays low.
- R6: A host access that hits the memory is counted from the first cycle `hs_sel` is high (cycle 0). There are three wait states, and `hs_ready` is high in cycle 4. On a read, `hs_rdata` holds the addressed dword while `hs_ready` is high.
- R7: A host access that misses the memory while `hs_reg_hit` is high has five wait states. `hs_ready` is high in cycle 6, with `hs_rdata` = 0, and the memory is left unchanged.
- R8: A host write to the memory changes only the byte lanes whose `hs_be` bit is set. Bit i covers data bits [8i+7:8i].
- R9: While the mirror bit is set, `scratch_q` returns `base_q`. While it is clear, `scratch_q` returns the last value written to the scratch register.
- R10: While `ram_en` is low, no address hits. Fetches go out on `cpu_bus_req`, and a host access without `hs_reg_hit` gets no `hs_ready`.
- R11: `hs_ready` is a one-cycle pulse for each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_en | input | 1 | Strap: 1 enables the memory |
| base_we | input | 1 | Write strobe for the base register |
| base_wdata | input | 32 | New base address (bits [11:0] ignored) |
| mirror_we | input | 1 | Write strobe for the mirror control bit |
| mirror_wdata | input | 1 | New mirror control bit value |
| scr_we | input | 1 | Write strobe for the scratch register |
| scr_wdata | input | 32 | New scratch register value |
| base_q | output | 32 | Current base address |
| scratch_q | output | 32 | Scratch register, or base address when mirrored |
| cpu_req | input | 1 | Processor access request |
| cpu_fetch | input | 1 | 1 when the request is an instruction fetch |
| cpu_addr | input | 32 | Processor address |
| cpu_bus_req | output | 1 | Request passed to the host-bus path |
| cpu_ack | output | 1 | Internal fetch answered |
| cpu_rdata | output | 32 | Fetched instruction dword |
| hs_sel | input | 1 | Host slave select, held until `hs_ready` |
| hs_reg_hit | input | 1 | External decode: address belongs to a register slave |
| hs_we | input | 1 | 1 for a host write |
| hs_be | input | 4 | Host byte enables |
| hs_addr | input | 32 | Host address |
| hs_wdata | input | 32 | Host write data |
| hs_ready | output | 1 | Host access complete |
| hs_rdata | output | 32 | Host read data, valid with `hs_ready` |

## Verification
The processor path is combinational for `cpu_bus_req`, so the bench samples it just after driving the request. It samples `cpu_ack` and `cpu_rdata` one clock edge later. For host accesses, the bench raises `hs_sel` between edges and counts edges until `hs_ready` is seen. It expects 4 for a memory hit and 6 for a register slave, and it checks that `hs_ready` is low again one edge after it dropped `hs_sel`. All sampling happens at the falling edge, away from the edge that updates the registers. Reads are compared with a dword model in the bench that applies each write lane by lane.

// File: rtl/iram_pkg.sv
package iram_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int DEPTH   = 1024;
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int WIN_LSB = IDX_W + $clog2(LANES);
    localparam int TAG_W   = ADDR_W - WIN_LSB;
    localparam int WS_RAM  = 3;
    localparam int WS_REG  = 5;
    localparam int CNT_W   = $clog2(WS_REG + 1);

    typedef enum logic [1:0] {SL_IDLE, SL_WAIT, SL_RESP} slv_state_e;

    typedef struct packed {
        logic              is_ram;
        logic              we;
        logic [LANES-1:0]  be;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
    } slv_req_t;

    function automatic logic [IDX_W-1:0] dword_idx(input logic [ADDR_W-1:0] a);
        return a[WIN_LSB-1:$clog2(LANES)];
    endfunction

    function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:WIN_LSB];
    endfunction
endpackage

// File: rtl/iram_cfg_regs.sv
module iram_cfg_regs
    import iram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              mirror_we,
    input  logic              mirror_wdata,
    input  logic              scr_we,
    input  logic [DATA_W-1:0] scr_wdata,
    output logic [TAG_W-1:0]  base_tag,
    output logic [ADDR_W-1:0] base_q,
    output logic [DATA_W-1:0] scratch_q
);
    logic              mirror_q;
    logic [DATA_W-1:0] scr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_tag <= '0;
            mirror_q <= 1'b0;
            scr_q    <= '0;
        end else begin
            if (base_we)   base_tag <= addr_tag(base_wdata);
            if (mirror_we) mirror_q <= mirror_wdata;
            if (scr_we)    scr_q    <= scr_wdata;
        end
    end

    assign base_q    = {base_tag, {WIN_LSB{1'b0}}};
    assign scratch_q = mirror_q ? base_q : scr_q;

    // R9: a mirrored scratch read follows a base change on the next cycle
    a_r9_mirror_follows: assert property (@(posedge clk) disable iff (rst)
        (mirror_q && !mirror_we && base_we) |=> (scratch_q == base_q));
endmodule

// File: rtl/iram_window_dec.sv
module iram_window_dec
    import iram_pkg::*;
(
    input  logic [TAG_W-1:0]  base_tag,
    input  logic              ram_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    assign hit = ram_en && (addr_tag(addr) == base_tag);
    assign idx = dword_idx(addr);
endmodule

// File: rtl/iram_store.sv
module iram_store
    import iram_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_be,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_q,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_q
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (wr_be[b]) mem[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end

    assign ra_q = mem[ra_idx];
    assign rb_q = mem[rb_idx];
endmodule

// File: rtl/iram_slave_fsm.sv
module iram_slave_fsm
    import iram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              ram_hit,
    input  logic              reg_hit,
    input  logic              we,
    input  logic [LANES-1:0]  be,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mem_q,
    output logic              mem_we,
    output logic [LANES-1:0]  mem_be,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata
);
    slv_state_e       state;
    logic [CNT_W-1:0] cnt;
    slv_req_t         lat;
    logic             last_ws;

    assign last_ws = (state == SL_WAIT) && (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SL_IDLE;
            cnt   <= '0;
            ready <= 1'b0;
            rdata <= '0;
            lat   <= '0;
        end else begin
            case (state)
                SL_IDLE: begin
                    ready <= 1'b0;
                    if (sel && (ram_hit || reg_hit)) begin
                        lat   <= '{is_ram: ram_hit, we: we, be: be, idx: idx, wdata: wdata};
                        cnt   <= ram_hit ? CNT_W'(WS_RAM) : CNT_W'(WS_REG);
                        state <= SL_WAIT;
                    end
                end
                SL_WAIT: begin
                    cnt <= cnt - CNT_W'(1);
                    if (last_ws) begin
                        ready <= 1'b1;
                        rdata <= lat.is_ram ? mem_q : '0;
                        state <= SL_RESP;
                    end
                end
                default: begin
                    ready <= 1'b0;
                    state <= SL_IDLE;
                end
            endcase
        end
    end

    assign mem_we    = last_ws && lat.is_ram && lat.we;
    assign mem_be    = lat.be;
    assign mem_idx   = lat.idx;
    assign mem_wdata = lat.wdata;

    // R11: ready lasts exactly one cycle
    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);
    // R6: memory accesses complete WS_RAM wait states after they are taken
    a_r6_ram_wait: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && lat.is_ram) |-> $past(state == SL_IDLE && sel && ram_hit, WS_RAM + 1));
    // R7: register slave accesses complete WS_REG wait states after they are taken
    a_r7_reg_wait: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && !lat.is_ram) |-> $past(state == SL_IDLE && sel && reg_hit && !ram_hit, WS_REG + 1));
endmodule

// File: rtl/reloc_iram_top.sv
module reloc_iram_top
    import iram_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ram_en,
    input  logic        base_we,
    input  logic [31:0] base_wdata,
    input  logic        mirror_we,
    input  logic        mirror_wdata,
    input  logic        scr_we,
    input  logic [31:0] scr_wdata,
    output logic [31:0] base_q,
    output logic [31:0] scratch_q,
    input  logic        cpu_req,
    input  logic        cpu_fetch,
    input  logic [31:0] cpu_addr,
    output logic        cpu_bus_req,
    output logic        cpu_ack,
    output logic [31:0] cpu_rdata,
    input  logic        hs_sel,
    input  logic        hs_reg_hit,
    input  logic        hs_we,
    input  logic [3:0]  hs_be,
    input  logic [31:0] hs_addr,
    input  logic [31:0] hs_wdata,
    output logic        hs_ready,
    output logic [31:0] hs_rdata
);
    logic [TAG_W-1:0]  base_tag;
    logic              cpu_hit, hs_hit, fetch_hit;
    logic [IDX_W-1:0]  cpu_idx, hs_idx, mem_idx;
    logic [DATA_W-1:0] fetch_q, host_q, mem_wdata;
    logic              mem_we;
    logic [LANES-1:0]  mem_be;

    iram_cfg_regs i_cfg (
        .clk(clk), .rst(rst),
        .base_we(base_we), .base_wdata(base_wdata),
        .mirror_we(mirror_we), .mirror_wdata(mirror_wdata),
        .scr_we(scr_we), .scr_wdata(scr_wdata),
        .base_tag(base_tag), .base_q(base_q), .scratch_q(scratch_q)
    );

    iram_window_dec i_cpu_dec (
        .base_tag(base_tag), .ram_en(ram_en), .addr(cpu_addr),
        .hit(cpu_hit), .idx(cpu_idx)
    );

    iram_window_dec i_hs_dec (
        .base_tag(base_tag), .ram_en(ram_en), .addr(hs_addr),
        .hit(hs_hit), .idx(hs_idx)
    );

    iram_store i_store (
        .clk(clk),
        .wr_en(mem_we), .wr_be(mem_be), .wr_idx(mem_idx), .wr_data(mem_wdata),
        .ra_idx(cpu_idx), .ra_q(fetch_q),
        .rb_idx(mem_idx), .rb_q(host_q)
    );

    iram_slave_fsm i_slave (
        .clk(clk), .rst(rst),
        .sel(hs_sel), .ram_hit(hs_hit), .reg_hit(hs_reg_hit),
        .we(hs_we), .be(hs_be), .idx(hs_idx), .wdata(hs_wdata),
        .mem_q(host_q),
        .mem_we(mem_we), .mem_be(mem_be), .mem_idx(mem_idx), .mem_wdata(mem_wdata),
        .ready(hs_ready), .rdata(hs_rdata)
    );

    assign fetch_hit   = cpu_req && cpu_fetch && cpu_hit;
    assign cpu_bus_req = cpu_req && !fetch_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_ack   <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            cpu_ack <= fetch_hit;
            if (fetch_hit) cpu_rdata <= fetch_q;
        end
    end

    // R4: a fetch inside the window is acknowledged on the next cycle
    a_r4_fetch_ack: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_fetch && cpu_hit) |=> cpu_ack);
    // R5: an acknowledge only follows a processor fetch request
    a_r5_ack_cause: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> $past(cpu_req && cpu_fetch));
    // R10: no internal answer is given while the strap is off
    a_r10_strap_off: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> $past(ram_en));
endmodule

// File: tb/test_reloc_iram_top.sv
module test_reloc_iram_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ram_en = 1'b1;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        mirror_we = 1'b0;
    logic        mirror_wdata = 1'b0;
    logic        scr_we = 1'b0;
    logic [31:0] scr_wdata = '0;
    logic [31:0] base_q, scratch_q;
    logic        cpu_req = 1'b0, cpu_fetch = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_bus_req, cpu_ack;
    logic [31:0] cpu_rdata;
    logic        hs_sel = 1'b0, hs_reg_hit = 1'b0, hs_we = 1'b0;
    logic [3:0]  hs_be = '0;
    logic [31:0] hs_addr = '0, hs_wdata = '0;
    logic        hs_ready;
    logic [31:0] hs_rdata;

    int vecs = 0;
    int errs = 0;
    bit done = 0;
    logic [31:0] model [1024];
    logic [31:0] base_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    reloc_iram_top i_reloc_iram_top (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    function automatic int wait_cycles(input bit is_ram);
        return is_ram ? 4 : 6;
    endfunction

    task automatic set_base(input logic [31:0] v);
        @(negedge clk); base_we = 1; base_wdata = v;
        @(negedge clk); base_we = 0;
        base_m = {v[31:12], 12'h000};
    endtask

    task automatic host_acc(input logic [31:0] a, input logic we, input logic [3:0] be,
                            input logic [31:0] wd, input logic regh,
                            output int n, output logic [31:0] rd);
        @(negedge clk);
        hs_sel = 1; hs_addr = a; hs_we = we; hs_be = be; hs_wdata = wd; hs_reg_hit = regh;
        n = 99; rd = 'x;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (hs_ready) begin n = k; rd = hs_rdata; break; end
        end
        hs_sel = 0; hs_reg_hit = 0; hs_we = 0;
        if (n != 99) begin
            @(negedge clk);
            chk("R11 ready pulse", {31'b0, hs_ready}, 32'd0);
        end
    endtask

    task automatic ram_write(input logic [31:0] a, input logic [3:0] be, input logic [31:0] wd, input string req);
        int n; logic [31:0] rd;
        host_acc(a, 1, be, wd, 0, n, rd);
        chk({req, " write wait"}, n, wait_cycles(1));
        model[a[11:2]] = merge(model[a[11:2]], wd, be);
    endtask

    task automatic ram_read(input logic [31:0] a, input string req);
        int n; logic [31:0] rd;
        host_acc(a, 0, 4'hF, 32'h0, 0, n, rd);
        chk({req, " read wait"}, n, wait_cycles(1));
        chk({req, " read data"}, rd, model[a[11:2]]);
    endtask

    task automatic fetch(input logic [31:0] a, input logic f, input bit exp_hit, input string req);
        @(negedge clk);
        cpu_req = 1; cpu_fetch = f; cpu_addr = a;
        #1;
        chk({req, " bus_req"}, {31'b0, cpu_bus_req}, {31'b0, !exp_hit});
        @(negedge clk);
        cpu_req = 0; cpu_fetch = 0;
        chk({req, " ack"}, {31'b0, cpu_ack}, {31'b0, exp_hit});
        if (exp_hit) chk({req, " fetch data"}, cpu_rdata, model[a[11:2]]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        logic [31:0] rd, a, d;
        logic [3:0] be;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 base", base_q, 32'h0);
        chk("R1 scratch", scratch_q, 32'h0);
        chk("R1 ready", {31'b0, hs_ready}, 32'h0);
        chk("R1 ack", {31'b0, cpu_ack}, 32'h0);

        // R2 low bits dropped
        set_base(32'h1234_5ABC);
        chk("R2 base aligned", base_q, 32'h1234_5000);

        // fill the window (R6)
        for (int i = 0; i < 1024; i++)
            ram_write(base_m + 32'(i*4), 4'hF, $urandom, "R6");
        for (int i = 0; i < 16; i++) ram_read(base_m + 32'(($urandom % 1024) * 4), "R6");

        // R8 random partial writes and reads
        for (int i = 0; i < 150; i++) begin
            a = base_m + 32'(($urandom % 1024) * 4) + 32'($urandom % 4);
            be = 4'($urandom);
            d = $urandom;
            ram_write(a, be, d, "R8");
            ram_read(a, "R8");
        end
        // R8 directed: single lane
        ram_write(base_m + 32'h10, 4'hF, 32'hAABB_CCDD, "R8");
        ram_write(base_m + 32'h10, 4'b0100, 32'h1122_3344, "R8");
        ram_read(base_m + 32'h10, "R8");
        chk("R8 single lane", model[4], 32'hAA22_CCDD);

        // R4 fetch hits
        for (int i = 0; i < 60; i++)
            fetch(base_m + 32'(($urandom % 1024) * 4), 1, 1, "R4");
        // R3 window edges
        fetch(base_m + 32'hFFC, 1, 1, "R3 top dword");
        fetch(base_m + 32'h1000, 1, 0, "R3 above window");
        fetch(base_m - 32'h4, 1, 0, "R3 below window");
        // R5 data access in window, fetch outside
        fetch(base_m + 32'h20, 0, 0, "R5 non-fetch");
        fetch(32'h0000_0100, 1, 0, "R5 miss");

        // R7 register slave
        host_acc(32'h0000_0040, 0, 4'hF, 0, 1, n, rd);
        chk("R7 reg wait", n, wait_cycles(0));
        chk("R7 reg rdata", rd, 32'h0);
        host_acc(32'h0000_0044, 1, 4'hF, 32'hFFFF_FFFF, 1, n, rd);
        chk("R7 reg write wait", n, wait_cycles(0));
        // R3 memory wins over register decode
        host_acc(base_m + 32'h30, 0, 4'hF, 0, 1, n, rd);
        chk("R3 priority wait", n, wait_cycles(1));
        chk("R3 priority data", rd, model[12]);

        // R9 mirror
        @(negedge clk); scr_we = 1; scr_wdata = 32'hDEAD_BEEF;
        @(negedge clk); scr_we = 0;
        chk("R9 scratch plain", scratch_q, 32'hDEAD_BEEF);
        @(negedge clk); mirror_we = 1; mirror_wdata = 1;
        @(negedge clk); mirror_we = 0;
        chk("R9 scratch mirrored", scratch_q, base_m);

        // R3 relocate: same contents at new base
        set_base(32'hFEDC_B000);
        chk("R9 mirror follows base", scratch_q, 32'hFEDC_B000);
        fetch(32'h1234_5000 + 32'h40, 1, 0, "R3 old base");
        fetch(32'hFEDC_B040, 1, 1, "R3 new base");
        ram_read(32'hFEDC_B7F0, "R3 new base");
        @(negedge clk); mirror_we = 1; mirror_wdata = 0;
        @(negedge clk); mirror_we = 0;
        chk("R9 scratch unmirrored", scratch_q, 32'hDEAD_BEEF);

        // R10 strap off
        @(negedge clk); ram_en = 0;
        fetch(32'hFEDC_B040, 1, 0, "R10 fetch");
        host_acc(32'hFEDC_B040, 0, 4'hF, 0, 0, n, rd);
        chk("R10 no ready", n, 99);
        host_acc(32'hFEDC_B044, 1, 4'hF, 32'h0, 1, n, rd);
        chk("R10 reg only", n, wait_cycles(0));
        @(negedge clk); ram_en = 1;
        ram_read(32'hFEDC_B044, "R10 untouched");

        // R1 reset again
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk("R1 base after reset", base_q, 32'h0);
        chk("R1 scratch after reset", scratch_q, 32'h0);
        finish_run();
    end
endmodule